// File: doc/BRIEF.md
# Mode and Fault Status Register

This block is the byte-wide mode register of a line-driver transceiver, together with the interrupt status register that belongs to it. Software reaches both through a simple parallel register bus. A one-bit address picks between them, there are separate write and read strobes, and read data is combinational.

The mode register holds four things software can set:
- a wake-up enable,
- a regulator-undervoltage output enable,
- a regulator-disable control,
- a self-clearing soft reset.

It also mirrors three live fault conditions: driver fault, supply undervoltage (gated by a logic-supply-present input) and overtemperature.

Each condition, plus a regulator-undervoltage condition, has a sticky bit in the status register. A sticky bit is set on the rising edge of its condition. A status read clears the sticky bits, and `irq` is high while any sticky bit is set.

A small controller with two states sequences the soft reset:
- `ST_RUN` is the normal state. It takes the transition `T_RST_REQ` to `ST_SOFTRST` when a mode write carries bit 7 = 1.
- `ST_SOFTRST` lasts exactly one cycle and always takes `T_RST_DONE` back to `ST_RUN`.

While the controller is in `ST_SOFTRST`, bit 7 reads 1, all writable bits and all sticky bits are 0, `irq` is low, no condition edge is recorded and writes are dropped.

Top module: `mfs_mode_reg`

## Requirements
- R1: After `rst_n` is released with all conditions low, the mode register (address 0) reads 0x00, the status register (address 1) reads 0x00, and `irq`, `uv_out`, `wake_en` and `reg_disable` are 0.
- R2: The mode register uses these bit positions:
  - Bit 6 is the wake-up enable. It is stored by a mode write, reads back, and drives `wake_en` from the cycle after the write.
  - Bit 1 is the undervoltage-output enable. It is stored by a mode write and reads back from the cycle after the write.
  - Bit 0 is the regulator disable. It is stored by a mode write, reads back, and drives `reg_disable` from the cycle after the write.
  - Bit 5 always reads 0.
- R3: Mode bits 4, 3 and 2 show the live driver-fault, supply-undervoltage and overtemperature conditions. Each follows its input one clock after the input changes, and a mode write never alters them.
- R4: Supply undervoltage counts, both as a live bit and as a sticky bit, only while `logic_sup_ok` is 1. A rise of `logic_sup_ok` while `sup_uv_in` is high counts as a new occurrence.
- R5: A condition that goes from 0 to 1 sets its sticky bit two clocks after the input rises. The status bits are:
  - bit 0: driver fault
  - bit 1: supply undervoltage
  - bit 2: overtemperature
  - bit 3: regulator undervoltage
  - bits 7..4: always 0

  A sticky bit stays set after its condition falls. A condition held high does not set its bit again after a clear.
- R6: `irq` is 1 exactly when some sticky bit is 1. A cycle with `bus_rd` = 1 at address 1 clears every sticky bit at the next edge, unless a rise is being recorded for that bit in the same cycle; in that case the bit stays set.
- R7: `uv_out` is 1 when mode bit 1 is set and the regulator-undervoltage condition (registered one clock) is high. The regulator-undervoltage sticky bit and `irq` behave the same whatever the value of bit 1.
- R8: A mode write with bit 7 = 1 puts the block into soft reset for one cycle. In that cycle:
  - mode bit 7 reads 1;
  - bits 6, 1 and 0 read 0, and `wake_en` and `reg_disable` are 0;
  - the status register reads 0 and `irq` is 0.

  In the following cycle bit 7 reads 0.
- R9: A condition rise that would be recorded in the soft-reset cycle is lost. A mode write issued during the soft-reset cycle has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low power-up reset |
| bus_addr | input | 1 | Register select: 0 mode, 1 status |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe (clears status when address is 1) |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data of the selected register |
| drv_fault_in | input | 1 | Driver fault condition |
| sup_uv_in | input | 1 | Supply undervoltage condition |
| ot_warn_in | input | 1 | Overtemperature warning condition |
| logic_sup_ok | input | 1 | Logic supply present; enables supply undervoltage sensing |
| reg_uv_in | input | 1 | Regulator undervoltage condition |
| irq | output | 1 | Interrupt request, active high |
| uv_out | output | 1 | Regulator undervoltage output |
| wake_en | output | 1 | Wake-up enable |
| reg_disable | output | 1 | Regulator disable |

## Verification
The bench targets the following corner cases:
- **Status read coinciding with a fresh condition edge.** A design that let the clear win would drop that interrupt.
- **Condition held high across a status read.** A level-triggered design would raise `irq` again at once.
- **Supply undervoltage while the logic supply is absent, then the supply returning.** A design that ignored the gating would report a false fault, or miss the deferred one.
- **The soft-reset cycle.** The bench fires an overtemperature edge and a mode write into that cycle. A design whose reset lasted longer, or that did not block edges and writes, would show the overtemperature interrupt, keep the written bits, or read bit 7 for the wrong number of cycles.
- **Mode writes while faults are live.** A design that stored bits 4..2 from the write data would show the written values instead of the conditions.

// File: rtl/mfs_pkg.sv
package mfs_pkg;
    localparam int REG_W   = 8;
    localparam int NUM_SRC = 4;

    // register addresses
    localparam logic ADDR_MODE   = 1'b0;
    localparam logic ADDR_STATUS = 1'b1;

    // condition source index == status bit position
    localparam int SRC_DRV = 0;
    localparam int SRC_SUP = 1;
    localparam int SRC_OT  = 2;
    localparam int SRC_REG = 3;

    // mode register bit positions
    localparam int B_RST  = 7;
    localparam int B_WAKE = 6;
    localparam int B_SPARE = 5;
    localparam int B_DRV  = 4;
    localparam int B_SUP  = 3;
    localparam int B_OT   = 2;
    localparam int B_UVEN = 1;
    localparam int B_DIS  = 0;

    typedef enum logic [0:0] {
        ST_RUN     = 1'b0,
        ST_SOFTRST = 1'b1
    } rst_state_t;
endpackage

// File: rtl/mfs_ctrl_fsm.sv
module mfs_ctrl_fsm
    import mfs_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic rst_wr_hit,
    output logic rst_req,
    output logic in_rst,
    output logic wr_ok
);
    rst_state_t state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_RUN;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_RUN:     if (rst_wr_hit) state_d = ST_SOFTRST;  // T_RST_REQ
            ST_SOFTRST: state_d = ST_RUN;                      // T_RST_DONE
            default:    state_d = ST_RUN;
        endcase
    end

    always_comb begin
        rst_req = 1'b0;
        in_rst  = 1'b0;
        wr_ok   = 1'b0;
        unique case (state_q)
            ST_RUN: begin
                rst_req = rst_wr_hit;
                wr_ok   = 1'b1;
            end
            ST_SOFTRST: begin
                in_rst = 1'b1;
            end
            default: ;
        endcase
    end

    // R8: soft reset lasts exactly one cycle
    a_r8_rst_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_SOFTRST) |=> (state_q == ST_RUN));
    // R9: no second reset request while already resetting
    a_r9_no_req_in_rst: assert property (@(posedge clk) disable iff (!rst_n)
        in_rst |-> !rst_req);
endmodule

// File: rtl/mfs_cond_track.sv
module mfs_cond_track #(
    parameter int N = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] raw,
    output logic [N-1:0] live,
    output logic [N-1:0] rise
);
    logic [N-1:0] prev_q;

    for (genvar i = 0; i < N; i++) begin : g_src
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                live[i]   <= 1'b0;
                prev_q[i] <= 1'b0;
            end else begin
                live[i]   <= raw[i];
                prev_q[i] <= live[i];
            end
        end
        assign rise[i] = live[i] & ~prev_q[i];
    end

    // R3: live value follows its input one clock later
    a_r3_live_follows: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (live == $past(raw)));
endmodule

// File: rtl/mfs_sticky_bank.sv
module mfs_sticky_bank #(
    parameter int N = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] set_pulse,
    input  logic         clr_rd,
    input  logic         clr_all,
    output logic [N-1:0] sticky,
    output logic         irq
);
    for (genvar i = 0; i < N; i++) begin : g_bit
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)            sticky[i] <= 1'b0;
            else if (clr_all)      sticky[i] <= 1'b0;
            else if (set_pulse[i]) sticky[i] <= 1'b1;
            else if (clr_rd)       sticky[i] <= 1'b0;
        end
    end

    assign irq = |sticky;

    // R6: a read with no concurrent edge empties the bank
    a_r6_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_rd && !clr_all && (set_pulse == '0)) |=> (sticky == '0));
    // R5: set bits stay set unless cleared
    a_r5_sticky_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr_rd && !clr_all) |=> ((sticky & $past(sticky)) == $past(sticky)));
    // R9: nothing survives a reset cycle
    a_r9_block_in_rst: assert property (@(posedge clk) disable iff (!rst_n)
        clr_all |=> (sticky == '0));
endmodule

// File: rtl/mfs_mode_reg.sv
module mfs_mode_reg
    import mfs_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bus_addr,
    input  logic             bus_wr,
    input  logic             bus_rd,
    input  logic [REG_W-1:0] bus_wdata,
    output logic [REG_W-1:0] bus_rdata,
    input  logic             drv_fault_in,
    input  logic             sup_uv_in,
    input  logic             ot_warn_in,
    input  logic             logic_sup_ok,
    input  logic             reg_uv_in,
    output logic             irq,
    output logic             uv_out,
    output logic             wake_en,
    output logic             reg_disable
);
    logic [NUM_SRC-1:0] raw, live, rise, sticky;
    logic rst_wr_hit, rst_req, in_rst, wr_ok;
    logic mode_wr, stat_rd;
    logic wake_q, uven_q, dis_q;
    logic [REG_W-1:0] mode_view, stat_view;

    assign raw[SRC_DRV] = drv_fault_in;
    assign raw[SRC_SUP] = sup_uv_in & logic_sup_ok;
    assign raw[SRC_OT]  = ot_warn_in;
    assign raw[SRC_REG] = reg_uv_in;

    assign rst_wr_hit = bus_wr && (bus_addr == ADDR_MODE) && bus_wdata[B_RST];
    assign mode_wr    = wr_ok && bus_wr && (bus_addr == ADDR_MODE);
    assign stat_rd    = bus_rd && (bus_addr == ADDR_STATUS);

    mfs_ctrl_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .rst_wr_hit (rst_wr_hit),
        .rst_req    (rst_req),
        .in_rst     (in_rst),
        .wr_ok      (wr_ok)
    );

    mfs_cond_track #(.N(NUM_SRC)) u_cond (
        .clk   (clk),
        .rst_n (rst_n),
        .raw   (raw),
        .live  (live),
        .rise  (rise)
    );

    mfs_sticky_bank #(.N(NUM_SRC)) u_sticky (
        .clk       (clk),
        .rst_n     (rst_n),
        .set_pulse (rise),
        .clr_rd    (stat_rd),
        .clr_all   (rst_req | in_rst),
        .sticky    (sticky),
        .irq       (irq)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wake_q <= 1'b0;
            uven_q <= 1'b0;
            dis_q  <= 1'b0;
        end else if (rst_req) begin
            wake_q <= 1'b0;
            uven_q <= 1'b0;
            dis_q  <= 1'b0;
        end else if (mode_wr) begin
            wake_q <= bus_wdata[B_WAKE];
            uven_q <= bus_wdata[B_UVEN];
            dis_q  <= bus_wdata[B_DIS];
        end
    end

    always_comb begin
        mode_view          = '0;
        mode_view[B_RST]   = in_rst;
        mode_view[B_WAKE]  = wake_q;
        mode_view[B_SPARE] = 1'b0;
        mode_view[B_DRV]   = live[SRC_DRV];
        mode_view[B_SUP]   = live[SRC_SUP];
        mode_view[B_OT]    = live[SRC_OT];
        mode_view[B_UVEN]  = uven_q;
        mode_view[B_DIS]   = dis_q;
        stat_view          = '0;
        stat_view[NUM_SRC-1:0] = sticky;
    end

    assign bus_rdata   = (bus_addr == ADDR_MODE) ? mode_view : stat_view;
    assign uv_out      = uven_q & live[SRC_REG];
    assign wake_en     = wake_q;
    assign reg_disable = dis_q;

    // R8: interrupt request stays low during the soft-reset cycle
    a_r8_irq_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        in_rst |-> !irq);
    // R3: a normal mode write leaves the live bits tracking conditions
    a_r3_live_ignores_write: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_wr && !bus_wdata[B_RST]) |=>
        ({live[SRC_DRV], live[SRC_SUP], live[SRC_OT]} ==
         $past({drv_fault_in, sup_uv_in & logic_sup_ok, ot_warn_in})));
    // R2: a normal write lands in the writable bits
    a_r2_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_wr && !bus_wdata[B_RST]) |=>
        ({wake_en, reg_disable} == $past({bus_wdata[B_WAKE], bus_wdata[B_DIS]})));
endmodule

// File: tb/tb_mfs_mode_reg.sv
module tb_mfs_mode_reg;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic bus_addr = 1'b0, bus_wr = 1'b0, bus_rd = 1'b0;
    logic [7:0] bus_wdata = 8'h00;
    logic [7:0] bus_rdata;
    logic drv_fault_in = 1'b0, sup_uv_in = 1'b0, ot_warn_in = 1'b0;
    logic logic_sup_ok = 1'b1, reg_uv_in = 1'b0;
    logic irq, uv_out, wake_en, reg_disable;

    int checks = 0;
    int failures = 0;
    string phase = "R1";
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    mfs_mode_reg dut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .drv_fault_in(drv_fault_in), .sup_uv_in(sup_uv_in),
        .ot_warn_in(ot_warn_in), .logic_sup_ok(logic_sup_ok),
        .reg_uv_in(reg_uv_in), .irq(irq), .uv_out(uv_out),
        .wake_en(wake_en), .reg_disable(reg_disable)
    );

    // behavioural reference state
    int m_in_rst, m_wake, m_uven, m_dis;
    int m_cur[4];
    int m_prev[4];
    int m_stk[4];

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    function automatic int exp_mode();
        return (m_in_rst << 7) | (m_wake << 6) | (m_cur[0] << 4) |
               (m_cur[1] << 3) | (m_cur[2] << 2) | (m_uven << 1) | m_dis;
    endfunction

    function automatic int exp_stat();
        return m_stk[0] | (m_stk[1] << 1) | (m_stk[2] << 2) | (m_stk[3] << 3);
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_in_rst = 0; m_wake = 0; m_uven = 0; m_dis = 0;
            for (int i = 0; i < 4; i++) begin
                m_cur[i] = 0; m_prev[i] = 0; m_stk[i] = 0;
            end
        end else begin
            int rst_go;
            int rd_clr;
            int inp[4];
            rst_go = (!m_in_rst && bus_wr && bus_addr == 1'b0 && bus_wdata[7]) ? 1 : 0;
            rd_clr = (bus_rd && bus_addr == 1'b1) ? 1 : 0;
            for (int i = 0; i < 4; i++) begin
                if (rst_go || m_in_rst) m_stk[i] = 0;
                else if (m_cur[i] && !m_prev[i]) m_stk[i] = 1;
                else if (rd_clr) m_stk[i] = 0;
            end
            if (rst_go) begin
                m_wake = 0; m_uven = 0; m_dis = 0;
            end else if (!m_in_rst && bus_wr && bus_addr == 1'b0) begin
                m_wake = bus_wdata[6]; m_uven = bus_wdata[1]; m_dis = bus_wdata[0];
            end
            m_in_rst = rst_go;
            inp[0] = drv_fault_in;
            inp[1] = sup_uv_in & logic_sup_ok;
            inp[2] = ot_warn_in;
            inp[3] = reg_uv_in;
            for (int i = 0; i < 4; i++) begin
                m_prev[i] = m_cur[i];
                m_cur[i] = inp[i];
            end
        end
    end

    // per-cycle comparison against the reference
    always @(negedge clk) begin
        if (rst_n && !done) begin
            chk({phase, " rdata"}, bus_rdata, bus_addr ? exp_stat() : exp_mode());
            chk({phase, " irq (R6)"}, irq, (exp_stat() != 0) ? 1 : 0);
            chk({phase, " uv_out (R7)"}, uv_out, m_uven & m_cur[3]);
            chk({phase, " wake_en (R2)"}, wake_en, m_wake);
            chk({phase, " reg_disable (R2)"}, reg_disable, m_dis);
        end
    end

    task automatic step(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic wr(input logic a, input logic [7:0] d);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        step(1);
        bus_wr = 1'b0;
    endtask

    task automatic peek(input logic a, input int exp, input string tag);
        bus_addr = a;
        #0.5;
        chk(tag, bus_rdata, exp);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        failures++;
        $display("FAIL R1 watchdog actual=timeout expected=finish");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        step(3);
        rst_n = 1'b1;
        step(2);
        // R1 reset state
        phase = "R1";
        peek(1'b0, 8'h00, "R1 mode after reset");
        peek(1'b1, 8'h00, "R1 status after reset");
        chk("R1 irq after reset", irq, 0);
        chk("R1 outputs after reset", {uv_out, wake_en, reg_disable}, 0);

        // R2 writable bits, bit5 reads 0
        phase = "R2";
        wr(1'b0, 8'h63);
        peek(1'b0, 8'h43, "R2 mode readback");
        chk("R2 wake_en", wake_en, 1);
        chk("R2 reg_disable", reg_disable, 1);
        wr(1'b0, 8'h02);
        peek(1'b0, 8'h02, "R2 second write");

        // R3 and R5: driver fault live + sticky
        phase = "R3";
        drv_fault_in = 1'b1;
        step(1);
        peek(1'b0, 8'h12, "R3 live driver bit");
        step(1);
        peek(1'b1, 8'h01, "R5 driver sticky set");
        chk("R6 irq on sticky", irq, 1);
        wr(1'b0, 8'h00);
        peek(1'b0, 8'h10, "R3 write keeps live bit");
        drv_fault_in = 1'b0;
        step(2);
        peek(1'b0, 8'h00, "R3 live bit cleared");
        peek(1'b1, 8'h01, "R5 sticky holds after fall");

        // R6 read clears; held level does not re-set
        phase = "R6";
        ot_warn_in = 1'b1;
        step(3);
        bus_addr = 1'b1; bus_rd = 1'b1;
        step(1);
        bus_rd = 1'b0;
        peek(1'b1, 8'h00, "R6 read cleared status");
        step(3);
        peek(1'b1, 8'h00, "R5 held level no re-set");
        chk("R6 irq low after clear", irq, 0);
        ot_warn_in = 1'b0;
        step(2);

        // R6 set wins over same-cycle read
        ot_warn_in = 1'b1;
        step(1);           // live now 1, rise pending this cycle
        bus_addr = 1'b1; bus_rd = 1'b1;
        step(1);
        bus_rd = 1'b0;
        peek(1'b1, 8'h04, "R6 rise beats read clear");
        bus_rd = 1'b1;
        step(1);
        bus_rd = 1'b0;
        ot_warn_in = 1'b0;
        step(2);

        // R4 supply undervoltage gating
        phase = "R4";
        logic_sup_ok = 1'b0;
        sup_uv_in = 1'b1;
        step(3);
        peek(1'b0, 8'h00, "R4 gated live bit");
        peek(1'b1, 8'h00, "R4 gated sticky");
        logic_sup_ok = 1'b1;
        step(2);
        peek(1'b0, 8'h08, "R4 live after supply ok");
        peek(1'b1, 8'h02, "R4 sticky after supply ok");
        sup_uv_in = 1'b0;
        bus_rd = 1'b1;
        step(1);
        bus_rd = 1'b0;
        step(2);

        // R7 regulator undervoltage
        phase = "R7";
        wr(1'b0, 8'h00);
        reg_uv_in = 1'b1;
        step(2);
        chk("R7 uv_out gated off", uv_out, 0);
        peek(1'b1, 8'h08, "R7 sticky regardless of enable");
        chk("R7 irq regardless of enable", irq, 1);
        wr(1'b0, 8'h02);
        chk("R7 uv_out enabled", uv_out, 1);
        reg_uv_in = 1'b0;
        bus_addr = 1'b1; bus_rd = 1'b1;
        step(1);
        bus_rd = 1'b0;
        step(2);

        // R8 / R9 soft reset
        phase = "R8";
        wr(1'b0, 8'h41);
        drv_fault_in = 1'b1;
        step(2);           // driver sticky now set
        chk("R8 irq before reset", irq, 1);
        ot_warn_in = 1'b1; // sampled at the reset-write edge
        wr(1'b0, 8'hC3);   // reset request; low bits must not stick
        peek(1'b0, 8'h94, "R8 reset cycle mode view");
        peek(1'b1, 8'h00, "R8 reset cycle status");
        chk("R8 irq low in reset", irq, 0);
        chk("R8 outputs cleared", {wake_en, reg_disable}, 0);
        phase = "R9";
        wr(1'b0, 8'h41);   // issued during reset cycle: dropped
        peek(1'b0, 8'h14, "R9 write in reset dropped, bit7 back to 0");
        step(2);
        peek(1'b1, 8'h00, "R9 edge in reset cycle lost");
        chk("R9 irq stays low", irq, 0);
        drv_fault_in = 1'b0;
        ot_warn_in = 1'b0;
        step(3);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule